// File: doc/BRIEF.md
# SSI Position Transmitter with Check Repeat

This block drives the serial data line of a position sensor that answers a synchronous-serial master. The master clocks out frames of 26 bits. In this mode each word is sent twice in a row. The master compares the second copy against the first to find line errors. After both copies have gone out, the next 26-clock burst carries a freshly captured position.

The master's clock line is asynchronous to the block's system clock. It is brought in through a two-stage synchroniser, and its edges are detected in the system domain. The first falling edge of a frame captures the position. Each rising edge then drives one bit onto the data line, MSB first. A monoflop counter measures the gap after the most recent edge. If the gap is longer than the timeout, the pending repeat is dropped, the data line returns to idle high, and the next burst carries fresh data.

Parameters set the position width, the width of the data field and the number of trailing status bits. The data field and the status bits together must fill the 26-bit frame. A position narrower than the data field is padded with zeros at the top. The position can be sent as binary or as Gray code.

Top module: `ssi_repeat_tx`

## Requirements
- R1: A frame is 26 rising edges of `ssi_clk` long and is sent MSB first. `sdata` changes only in response to a rising edge of `ssi_clk`, or when the timeout expires.
- R2: When the gap before the next frame is within the timeout, that frame (clocks 27 to 52) repeats the stored 26-bit word unchanged, even if `pos` has changed since.
- R3: A frame that follows a repeat frame (clock 53 onward) carries a newly captured position, so no word is sent more than twice.
- R4: If more than TIMEOUT_CYC system cycles pass without an `ssi_clk` edge, the pending repeat is cancelled and the next frame carries a newly captured position.
- R5: The frame layout, from first bit to last, is: DATA_BITS-POS_W zero bits, then the position code from bit POS_W-1 down to bit 0, then `special` from bit SPEC_BITS-1 down to bit 0. With `special` at zero, the trailing bits are sent as zeros.
- R6: With `gray_en`=1 the position code is pos XOR (pos >> 1). With `gray_en`=0 it is pos unchanged.
- R7: `sdata` is 1 after reset, and it returns to 1 when the timeout expires.
- R8: The position is sampled at the first falling edge of a new frame. A change of `pos` later in that frame does not alter the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssi_clk | input | 1 | Master serial clock, idles high, asynchronous |
| pos | input | POS_W | Parallel position word |
| gray_en | input | 1 | 1 selects Gray code, 0 selects binary |
| special | input | SPEC_BITS | Status bits appended after the position LSB |
| sdata | output | 1 | Serial data line to the master |

## Verification
The bench keeps the default 22-bit position in a 24-bit data field with two status bits, so every frame carries two leading pad zeros and a visible status tail. It shortens the monoflop timeout to 100 system cycles, so that both short gaps (the repeat is kept) and long gaps (the repeat is cancelled) fit into a short run. Directed sequences cover the repeat, the fresh word at clock 53, and a position change in the middle of a frame. Random sequences mix codes, status bits and gap lengths against a frame model kept in the bench.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
   localparam int FRAME_LEN = 26;
   localparam int MAX_SPEC  = 8;
   typedef logic [FRAME_LEN-1:0] frame_t;
endpackage

// File: rtl/ssi_edge_sync.sv
module ssi_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic rise,
   output logic fall
);
   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], line_in};
   end

   assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
   assign fall = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/ssi_frame_build.sv
module ssi_frame_build
   import ssi_pkg::*;
#(
   parameter int POS_W        = 22,
   parameter int DATA_BITS    = 24,
   parameter int SPEC_BITS    = 2,
   parameter bit GRAY_SUPPORT = 1'b1
) (
   input  logic [POS_W-1:0]     pos,
   input  logic                 gray_en,
   input  logic [SPEC_BITS-1:0] special,
   output frame_t               word
);
   localparam int PAD_W = DATA_BITS - POS_W;

   logic [POS_W-1:0] code;

   generate
      if (GRAY_SUPPORT) begin : g_gray
         assign code = gray_en ? (pos ^ (pos >> 1)) : pos;
      end else begin : g_bin
         logic unused_gray;
         assign unused_gray = gray_en;
         assign code = pos;
      end

      if (PAD_W > 0) begin : g_pad
         assign word = {{PAD_W{1'b0}}, code, special};
      end else begin : g_nopad
         assign word = {code, special};
      end
   endgenerate
endmodule

// File: rtl/ssi_mono_timer.sv
module ssi_mono_timer #(
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expire
);
   localparam int TW = $clog2(TIMEOUT_CYC + 1);

   logic [TW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (restart) begin
         cnt <= '0;
         run <= 1'b1;
      end else if (run) begin
         if (cnt == TW'(TIMEOUT_CYC - 1)) run <= 1'b0;
         else                             cnt <= cnt + 1'b1;
      end
   end

   assign expire = run && !restart && (cnt == TW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/ssi_repeat_tx.sv
module ssi_repeat_tx
   import ssi_pkg::*;
#(
   parameter int POS_W        = 22,
   parameter int DATA_BITS    = 24,
   parameter int SPEC_BITS    = 2,
   parameter int TIMEOUT_CYC  = 1000,
   parameter bit GRAY_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ssi_clk,
   input  logic [POS_W-1:0]     pos,
   input  logic                 gray_en,
   input  logic [SPEC_BITS-1:0] special,
   output logic                 sdata
);
   localparam int CNT_W = $clog2(FRAME_LEN);

   generate
      if (DATA_BITS + SPEC_BITS != FRAME_LEN) begin : g_chk_len
         $error("data field plus status bits must fill the frame");
      end
      if (SPEC_BITS < 1 || SPEC_BITS > MAX_SPEC) begin : g_chk_spec
         $error("status bit count out of range");
      end
      if (POS_W < 1 || POS_W > DATA_BITS) begin : g_chk_pos
         $error("position wider than data field");
      end
      if (TIMEOUT_CYC < 2) begin : g_chk_tmo
         $error("timeout too short");
      end
   endgenerate

   logic       rise, fall, expire;
   frame_t     built, store, shift;
   logic [CNT_W-1:0] bit_cnt;
   logic       in_frame, rep_pending, first_send;
   logic       frame_start, latch_new;

   ssi_edge_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(ssi_clk), .rise(rise), .fall(fall)
   );

   ssi_frame_build #(
      .POS_W(POS_W), .DATA_BITS(DATA_BITS), .SPEC_BITS(SPEC_BITS),
      .GRAY_SUPPORT(GRAY_SUPPORT)
   ) u_build (
      .pos(pos), .gray_en(gray_en), .special(special), .word(built)
   );

   ssi_mono_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(rise | fall), .expire(expire)
   );

   assign frame_start = fall && !in_frame;
   assign latch_new   = frame_start && !rep_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store       <= '0;
         shift       <= '0;
         bit_cnt     <= '0;
         in_frame    <= 1'b0;
         rep_pending <= 1'b0;
         first_send  <= 1'b0;
         sdata       <= 1'b1;
      end else if (expire) begin
         bit_cnt     <= '0;
         in_frame    <= 1'b0;
         rep_pending <= 1'b0;
         first_send  <= 1'b0;
         sdata       <= 1'b1;
      end else begin
         if (frame_start) begin
            in_frame <= 1'b1;
            bit_cnt  <= '0;
            if (rep_pending) begin
               shift       <= store;
               rep_pending <= 1'b0;
               first_send  <= 1'b0;
            end else begin
               shift      <= built;
               store      <= built;
               first_send <= 1'b1;
            end
         end
         if (rise && in_frame) begin
            sdata <= shift[FRAME_LEN-1];
            shift <= {shift[FRAME_LEN-2:0], 1'b0};
            if (bit_cnt == CNT_W'(FRAME_LEN - 1)) begin
               bit_cnt     <= '0;
               in_frame    <= 1'b0;
               rep_pending <= first_send;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ssi_repeat_tx_chk.sv
module ssi_repeat_tx_chk #(
   parameter int FRAME_LEN = 26,
   parameter int CNT_W     = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rise,
   input logic             fall,
   input logic             expire,
   input logic             in_frame,
   input logic             rep_pending,
   input logic             latch_new,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             sdata
);
   logic [1:0] sends;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sends <= '0;
      else if (fall && !in_frame) begin
         if (latch_new)       sends <= 2'd1;
         else if (sends != 3) sends <= sends + 1'b1;
      end
   end

   AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise && !expire) |=> $stable(sdata)); // R1
   AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && in_frame && bit_cnt == CNT_W'(FRAME_LEN - 1)) |=> !in_frame); // R1
   AST_REPEAT_ARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rep_pending |-> !in_frame); // R2
   AST_AT_MOST_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
      sends <= 2'd2); // R3
   AST_TIMEOUT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !rep_pending); // R4
   AST_TIMEOUT_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> sdata); // R7
endmodule

bind ssi_repeat_tx ssi_repeat_tx_chk #(
   .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .expire(expire),
   .in_frame(in_frame), .rep_pending(rep_pending), .latch_new(latch_new),
   .bit_cnt(bit_cnt), .sdata(sdata)
);

// File: tb/tb_ssi_repeat_tx.sv
module tb_ssi_repeat_tx;
   localparam int POS_W     = 22;
   localparam int DATA_BITS = 24;
   localparam int SPEC_BITS = 2;
   localparam int TMO       = 100;
   localparam int FL        = 26;
   localparam int H         = 10;
   localparam int SHORT_GAP = 20;
   localparam int LONG_GAP  = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ssi_clk = 1'b1;
   logic [POS_W-1:0] pos = '0;
   logic gray_en = 1'b0;
   logic [SPEC_BITS-1:0] special = '0;
   logic sdata;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   ssi_repeat_tx #(
      .POS_W(POS_W), .DATA_BITS(DATA_BITS), .SPEC_BITS(SPEC_BITS),
      .TIMEOUT_CYC(TMO), .GRAY_SUPPORT(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ssi_clk(ssi_clk), .pos(pos),
      .gray_en(gray_en), .special(special), .sdata(sdata)
   );

   function automatic logic [FL-1:0] exp_word(logic [POS_W-1:0] p, logic g,
                                              logic [SPEC_BITS-1:0] s);
      logic [POS_W-1:0] c;
      c = g ? (p ^ (p >> 1)) : p;
      return {{(DATA_BITS-POS_W){1'b0}}, c, s};
   endfunction

   task automatic check(string req, logic [FL-1:0] got, logic [FL-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic run_frame(input logic [POS_W-1:0] mid_pos,
                            output logic [FL-1:0] got);
      for (int i = FL - 1; i >= 0; i--) begin
         ssi_clk = 1'b0;
         repeat (H) @(negedge clk);
         if (i == FL - 6) pos = mid_pos;
         ssi_clk = 1'b1;
         repeat (H) @(negedge clk);
         got[i] = sdata;
      end
   endtask

   task automatic gap(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [FL-1:0] got, w_a, w_b, stored;
      logic [POS_W-1:0] pa, pb;
      logic have_rep;
      void'($urandom(32'h5eed_1234));

      gap(5);
      rst_n = 1'b1;
      gap(5);
      check("R7 reset idle", {25'd0, sdata}, 26'd1);

      // R5 R1 R8 R2 R3: directed sequence, short gaps
      pa = 22'h2A_5C31; pb = 22'h13_0F0E;
      pos = pa; gray_en = 1'b0; special = 2'b10;
      w_a = exp_word(pa, 1'b0, 2'b10);
      run_frame(pb, got);
      check("R5 R1 R8 first frame", got, w_a);
      gap(SHORT_GAP);
      run_frame(pb, got);
      check("R2 repeat frame", got, w_a);
      gap(SHORT_GAP);
      w_b = exp_word(pb, 1'b0, 2'b10);
      run_frame(pb, got);
      check("R3 clock 53 fresh", got, w_b);
      gap(SHORT_GAP);
      run_frame(pb, got);
      check("R2 repeat of fresh", got, w_b);
      gap(LONG_GAP);
      check("R7 idle after timeout", {25'd0, sdata}, 26'd1);

      // R4: long gap cancels the repeat
      pos = 22'h3F_FFFF; special = 2'b00;
      run_frame(22'h00_0001, got);
      check("R5 all ones zero tail", got, exp_word(22'h3F_FFFF, 1'b0, 2'b00));
      gap(LONG_GAP);
      run_frame(22'h00_0001, got);
      check("R4 timeout cancels repeat", got, exp_word(22'h00_0001, 1'b0, 2'b00));
      gap(LONG_GAP);

      // R6: Gray code
      pos = 22'h1B_7A3C; gray_en = 1'b1; special = 2'b11;
      run_frame(22'h1B_7A3C, got);
      check("R6 gray frame", got, exp_word(22'h1B_7A3C, 1'b1, 2'b11));
      gap(SHORT_GAP);
      gray_en = 1'b0;
      run_frame(22'h1B_7A3C, got);
      check("R2 R6 repeat keeps gray", got, exp_word(22'h1B_7A3C, 1'b1, 2'b11));
      gap(LONG_GAP);

      // random mix against a frame model
      have_rep = 1'b0;
      stored = '0;
      for (int k = 0; k < 24; k++) begin
         logic [POS_W-1:0] np, mp;
         logic long_g;
         np = POS_W'($urandom);
         mp = POS_W'($urandom);
         pos = np;
         gray_en = 1'($urandom);
         special = SPEC_BITS'($urandom);
         if (have_rep) begin
            have_rep = 1'b0;
         end else begin
            stored = exp_word(np, gray_en, special);
            have_rep = 1'b1;
         end
         run_frame(mp, got);
         check("R2 R3 R6 R8 random frame", got, stored);
         long_g = ($urandom % 3) == 0;
         if (long_g) begin
            gap(LONG_GAP);
            have_rep = 1'b0;
            check("R4 R7 random idle", {25'd0, sdata}, 26'd1);
         end else begin
            gap(SHORT_GAP);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule